// File: doc/BRIEF.md
# Predicate-to-Vector Bit Insert Unit

This datapath block takes a vector predicate in which each vector byte owns one bit, and keeps only the bits that govern 64-bit elements. It places that compact group of bits into one of eight equal slots in the low eighth of a destination vector. A 3-bit slot index selects the slot. The same index also decides what happens to every other destination bit. Slot zero clears all of them, so the result starts from a clean zero vector. Any other slot merges: the remaining bits are copied from an old-vector input, which lets eight successive inserts build up a packed mask word.

The vector length `VL` is a parameter, a power of two from 128 to 2048 bits. A request is a single cycle with `inValid` high. The result is registered and appears on the next clock edge, marked by `outValid`.

Top module: `pred_vec_insert`

## Requirements
- R1: The gathered group holds VL/64 bits. Gathered bit k is predicate input bit 8k.
- R2: Predicate bits whose index is not a multiple of 8 have no effect on the result.
- R3: Gathered bit k is written to destination bit (VL/64)*slot + k, where slot is the 3-bit unsigned `inSlot` (0..7). The lowest element goes to the lowest bit, so all slots lie within the low VL/8 bits.
- R4: When `inSlot` is 0, every destination bit outside the written group is 0.
- R5: When `inSlot` is nonzero, every destination bit outside the written group equals the same bit of `inOld`.
- R6: A request sampled with `inValid` high at a rising edge drives its result on `outVec`, with `outValid` high, from that edge until the next one. `outValid` is low after any edge where `inValid` was low, and back-to-back requests are accepted every cycle.
- R7: While no request is sampled, `outVec` keeps its last value, whatever `inPred`, `inOld` or `inSlot` do.
- R8: A synchronous active-high `rst` clears `outValid` and `outVec` to 0.
- R9: R1 to R5 hold for every supported VL (128, 256, 512, 1024, 2048).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; inputs are sampled when high |
| inPred | input | VL/8 | Predicate, one bit per vector byte |
| inOld | input | VL | Old destination vector, used for merging |
| inSlot | input | 3 | Slot index; zero also selects clearing |
| outValid | output | 1 | High in the cycle the result is presented |
| outVec | output | VL | Registered result vector |

## Verification
A fault in the fill control shows up in the first result after a request. A wrong clear/merge decision flips bits outside the slot: they turn to zero where old bits should survive, or old bits leak through where zero is required. A wrong slot offset moves the group to bits that the reference expects elsewhere. A faulty hold or valid register shows up either as an `outVec` that drifts while `inValid` is low, or as `outValid` out of step with the request by one cycle. The sweep covers every slot value with several predicate and old-vector patterns at two vector lengths, so every result bit is compared against a per-bit reference at least once.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam int SLOT_W = 3;
  localparam int SLOT_COUNT = 1 << SLOT_W;

  typedef struct packed {
    logic              captureEn;
    logic              clearFill;
    logic [SLOT_W-1:0] slot;
  } pvi_strobe_t;
endpackage

// File: rtl/pvi_ctrl.sv
module pvi_ctrl
  import pvi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inSlot,
  output pvi_strobe_t       strobes,
  output logic              outValid
);

  always_comb begin
    strobes.captureEn = inValid;
    strobes.clearFill = (inSlot == '0);
    strobes.slot      = inSlot;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R6: result strobe follows a request by exactly one cycle
  p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/pvi_datapath.sv
module pvi_datapath
  import pvi_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  pvi_strobe_t      strobes,
  input  logic [VL/8-1:0]  inPred,
  input  logic [VL-1:0]    inOld,
  output logic [VL-1:0]    outVec
);

  localparam int ELEMS   = VL / 64;
  localparam int SHIFT_W = $clog2(VL);
  localparam logic [VL-1:0] LOW_ONES = {{(VL-ELEMS){1'b0}}, {ELEMS{1'b1}}};

  logic [ELEMS-1:0]   gathered;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [VL-1:0]      groupMask;
  logic [VL-1:0]      fillVec;
  logic [VL-1:0]      placedGroup;
  logic [VL-1:0]      nextVec;

  // One predicate bit per 64-bit element: the lowest bit of each byte group
  for (genvar k = 0; k < ELEMS; k++) begin : g_gather
    assign gathered[k] = inPred[8*k];
  end

  always_comb begin
    shiftAmt    = SHIFT_W'(strobes.slot) * SHIFT_W'(ELEMS);
    groupMask   = LOW_ONES << shiftAmt;
    fillVec     = strobes.clearFill ? '0 : inOld;
    placedGroup = {{(VL-ELEMS){1'b0}}, gathered} << shiftAmt;
    nextVec     = (fillVec & ~groupMask) | placedGroup;
  end

  always_ff @(posedge clk) begin
    if (rst)                    outVec <= '0;
    else if (strobes.captureEn) outVec <= nextVec;
  end

  // R7: no request, no change
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.captureEn |=> $stable(outVec));
  // R4: zero slot leaves nothing outside the group
  p_clear_outside_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.captureEn && strobes.slot == '0) |=>
      ((outVec & ~$past(groupMask)) == '0));
  // R5: nonzero slot keeps old bits outside the group
  p_merge_outside_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.captureEn && strobes.slot != '0) |=>
      (((outVec ^ $past(inOld)) & ~$past(groupMask)) == '0));
  // R3: the group never strays above the low eighth
  p_group_low_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.captureEn |-> ((groupMask >> (VL/8)) == '0));

endmodule

// File: rtl/pred_vec_insert.sv
module pred_vec_insert
  import pvi_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VL/8-1:0]  inPred,
  input  logic [VL-1:0]    inOld,
  input  logic [2:0]       inSlot,
  output logic             outValid,
  output logic [VL-1:0]    outVec
);

  pvi_strobe_t strobes;

  pvi_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inSlot   (inSlot),
    .strobes  (strobes),
    .outValid (outValid)
  );

  pvi_datapath #(.VL(VL)) data_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inPred  (inPred),
    .inOld   (inOld),
    .outVec  (outVec)
  );

endmodule

// File: tb/pred_vec_insert_tb_top.sv
`timescale 1ns/1ps
module pred_vec_insert_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [63:0]  pred = '0;
  logic [511:0] old = '0;
  logic [2:0]   slot = '0;
  logic         outValidN, outValidW;
  logic [127:0] outN;
  logic [511:0] outW;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // R9: two vector lengths driven with the same stimulus
  pred_vec_insert #(.VL(128)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inPred(pred[15:0]),
    .inOld(old[127:0]), .inSlot(slot), .outValid(outValidN), .outVec(outN));

  pred_vec_insert #(.VL(512)) dutWide_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inPred(pred),
    .inOld(old), .inSlot(slot), .outValid(outValidW), .outVec(outW));

  function automatic logic [511:0] refCalc(int vl, logic [63:0] p,
                                           logic [511:0] o, int imm);
    logic [511:0] r = '0;
    int elems = vl / 64;
    for (int b = 0; b < vl; b++) r[b] = (imm == 0) ? 1'b0 : o[b];
    for (int k = 0; k < elems; k++) r[imm*elems + k] = p[8*k];
    return r;
  endfunction

  task automatic checkVec(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkBoth(string req, logic [63:0] p, logic [511:0] o, int imm);
    checkVec({req, " VL128"}, {384'b0, outN}, refCalc(128, p, o, imm));
    checkVec({req, " VL512"}, outW, refCalc(512, p, o, imm));
  endtask

  task automatic applyOne(string req, logic [63:0] p, logic [511:0] o, int imm);
    @(negedge clk);
    pred = p; old = o; slot = 3'(imm); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R6 valid VL128", outValidN, 1'b1);
    checkBit("R6 valid VL512", outValidW, 1'b1);
    checkBoth(req, p, o, imm);
  endtask

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [63:0]  p, pA, pB;
    logic [511:0] o, oA, oB, held;
    string tag;
    repeat (3) @(negedge clk);
    // R8: reset state
    checkBit("R8 valid VL128", outValidN, 1'b0);
    checkBit("R8 valid VL512", outValidW, 1'b0);
    checkVec("R8 vec VL128", {384'b0, outN}, '0);
    checkVec("R8 vec VL512", outW, '0);
    rst = 1'b0;

    // R1, R3, R4, R5 sweep: every slot, several patterns
    for (int pat = 0; pat < 10; pat++) begin
      for (int imm = 0; imm < 8; imm++) begin
        case (pat)
          0: begin p = '1; o = '0; end
          1: begin p = '0; o = '1; end
          2: begin p = 64'h0101_0101_0101_0101; o = {16{32'hA5A5_5A5A}}; end
          default: begin p = {$urandom, $urandom}; o = rand512(); end
        endcase
        tag = (imm == 0) ? "R1,R3,R4,R9" : "R1,R3,R5,R9";
        applyOne(tag, p, o, imm);
      end
    end

    // R2: only non-element predicate bits set -> group is all zeros
    for (int imm = 0; imm < 8; imm++) begin
      applyOne("R2", 64'hFEFE_FEFE_FEFE_FEFE, rand512(), imm);
      checkVec("R2 group VL512", (outW >> (imm*8)) & 512'hFF, '0);
    end

    // R6: back-to-back requests
    pA = {$urandom, $urandom}; oA = rand512();
    pB = {$urandom, $urandom}; oB = rand512();
    @(negedge clk);
    pred = pA; old = oA; slot = 3'd5; inValid = 1'b1;
    @(negedge clk);
    checkBoth("R6 first", pA, oA, 5);
    pred = pB; old = oB; slot = 3'd0;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R6 second valid", outValidW, 1'b1);
    checkBoth("R6 second", pB, oB, 0);
    @(negedge clk);
    checkBit("R6 idle valid VL128", outValidN, 1'b0);
    checkBit("R6 idle valid VL512", outValidW, 1'b0);

    // R7: hold with changing inputs and no request
    applyOne("R7 setup", {$urandom, $urandom}, rand512(), 3);
    held = outW;
    for (int i = 0; i < 4; i++) begin
      pred = {$urandom, $urandom}; old = rand512(); slot = 3'(i);
      @(negedge clk);
      checkVec("R7 hold VL512", outW, held);
      checkBit("R7 valid low", outValidW, 1'b0);
    end

    // R8: reset mid-run clears result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkVec("R8 re-reset VL512", outW, '0);
    checkVec("R8 re-reset VL128", {384'b0, outN}, '0);
    finishRun();
  end

endmodule